// File: doc/BRIEF.md
# Serial EEPROM Boot Loader Sequencer

This block performs a single boot download from an external serial EEPROM after reset. On a load request it drives a byte-level command interface to a separate I2C master engine. It sends a start and the device write address. It then sends two bytes of EEPROM memory offset, a repeated start with no stop before it, and the device read address. After that it reads sequentially. The first three bytes read form a header. Bytes 0 and 1 are a 16-bit length, most significant byte first. Byte 2 selects the target memory. The next `length` bytes are written through a memory-write port, with addresses counting up from 0.

An open-drain style GPIO busy flag is pulled low for the whole load. A status word reports the outcome and keeps one load-error bit per target memory. If the EEPROM does not acknowledge its address, the loader takes this to mean no device is present and falls back to the default configuration. Any other fault ends the load as a fatal error. After any outcome the master bus stays silent until the next reset.

Top module: `boot_loader_top`

## Requirements
- R1: While `rst_n` is low, and after reset until a `load_req` pulse is seen, `cmd_valid` is 0, `gpio_pull_low` is 0 and `stat_word` is 0.
- R2: The device byte is {4'b1010, 2'b00, cs, rw}. It is sent with rw=0 after the start and with rw=1 after the repeated start. `cs` is the value of `cs_pin` sampled on the `load_req` cycle.
- R3: The commands are issued in this order: START (op 0), device write byte, offset high byte, offset low byte (ops 2 = WRITE), RSTART (op 1), device read byte, reads, STOP (op 5). No STOP comes before the final one.
- R4: Read bytes 0 and 1 give the data length, most significant byte first. Byte 2 selects the memory. Data byte k is written with `mem_addr`=k, `mem_sel`=selector and `mem_wdata`=byte, in a one-cycle `mem_we` pulse.
- R5: Every read uses op 3 (read and acknowledge), except the final data byte, which uses op 4 (read, no acknowledge) and is followed by STOP.
- R6: `stat_word` bits are: 0 done, 1 success, 2 no device, 3 fatal, 4 timeout, 5 bad header, 6 write NACK, 8+m load-error bit of memory m. A clean load ends with 16'h0003.
- R7: A NACK on the first device write byte sets done and no-device, leaves fatal clear, and issues STOP next.
- R8: A NACK on any later written byte sets done, fatal and write-NACK, and issues STOP next.
- R9: A length of 0, a length above 2^AW, or a selector of NUM_MEM or more sets done, fatal and bad-header. STOP follows and no memory write occurs.
- R10: If a command gets no response within TIMEOUT_CYC cycles, the loader sets done, fatal and timeout, withdraws the command, and issues no STOP.
- R11: A memory's load-error bit is set when its data phase begins. Only a successful finish clears it.
- R12: `gpio_pull_low` is 1 from the cycle after `load_req` is accepted until done is set, and 0 after that.
- R13: After done, `load_req` is ignored. No command is issued and `stat_word` does not change until reset.
- R14: `use_default` is 1 exactly when done is set without success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_req | input | 1 | Single-cycle request to start the boot load |
| cs_pin | input | 1 | Chip-select strap, selects the device address bit |
| cmd_valid | output | 1 | Command pending to the I2C master engine |
| cmd_op | output | 3 | Command code (0 START, 1 RSTART, 2 WRITE, 3 read+ACK, 4 read+NACK, 5 STOP) |
| cmd_wdata | output | 8 | Byte to send for WRITE |
| rsp_done | input | 1 | One-cycle pulse: pending command finished |
| rsp_nack | input | 1 | With `rsp_done`: written byte was not acknowledged |
| rsp_rdata | input | 8 | With `rsp_done`: byte read |
| mem_we | output | 1 | Memory write strobe |
| mem_sel | output | MSEL_W | Target memory selector |
| mem_addr | output | AW | Write address within the target memory |
| mem_wdata | output | 8 | Write data |
| gpio_pull_low | output | 1 | Drive the busy GPIO low (1) or release it (0) |
| use_default | output | 1 | Load failed; default configuration applies |
| stat_word | output | 16 | Status word |

## Verification
A table of load scenarios is run, with a full reset before each one. It covers clean loads of one byte, several bytes and the maximum length, with both chip-select values. It covers a NACK at each written byte position, each kind of bad header, and a hang at the start, during the header and during the data phase. Each scenario tells apart no-device from fatal outcomes and shows whether STOP is present. It also shows where the NACK read falls and how many memory writes happened. Toggling `cs_pin` after the request shows that the address bit is sampled at the request. A request repeated after each outcome shows that the bus stays silent for good.

// File: rtl/boot_pkg.sv
// Shared definitions for the boot loader: command codes, sequencer
// states, fault flags and the device-address helper.
package boot_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RSTART  = 3'd1,
        OP_WRITE   = 3'd2,
        OP_RD_ACK  = 3'd3,
        OP_RD_NACK = 3'd4,
        OP_STOP    = 3'd5
    } bus_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_DEVW, ST_AHI, ST_ALO, ST_RSTART,
        ST_DEVR, ST_HDR, ST_HCHK, ST_DATA, ST_STOP, ST_DONE
    } seq_st_e;

    typedef struct packed {
        logic nack;
        logic bad_hdr;
        logic timeout;
        logic no_dev;
    } fault_t;

    localparam logic [5:0] DEV_PREFIX = 6'b101000;

    // Device byte: fixed prefix, strap bit, direction bit (1 = read).
    function automatic logic [7:0] dev_byte(input logic cs, input logic rd);
        return {DEV_PREFIX, cs, rd};
    endfunction

endpackage

// File: rtl/boot_wdog.sv
// Response watchdog: counts consecutive cycles that a command is pending
// without an answer and pulses expire on the TIMEOUT_CYC-th such cycle.
// Assumes TIMEOUT_CYC >= 1.
module boot_wdog #(
    parameter int unsigned TIMEOUT_CYC = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    input  logic answered,
    output logic expire
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Count the unanswered cycles; restart when idle or answered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (waiting && !answered)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end

    // Expire on the last allowed cycle of an unanswered command.
    always_comb expire = waiting && !answered && (cnt_q == CNT_W'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/boot_hdr.sv
// Header capture and check: stores the three header bytes (length high,
// length low, memory selector) and flags a header that cannot be loaded.
// Assumes AW <= 16.
module boot_hdr #(
    parameter int unsigned AW      = 10,
    parameter int unsigned NUM_MEM = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  idx,
    input  logic [7:0]  din,
    output logic [15:0] len,
    output logic [7:0]  mtype,
    output logic        bad
);
    localparam int unsigned MAX_LEN = 1 << AW;

    logic [7:0] len_hi_q, len_lo_q, mt_q;

    // Latch each header byte into its slot as it arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_hi_q <= '0;
            len_lo_q <= '0;
            mt_q     <= '0;
        end else if (we) begin
            case (idx)
                2'd0:    len_hi_q <= din;
                2'd1:    len_lo_q <= din;
                default: mt_q     <= din;
            endcase
        end
    end

    // Assemble fields and judge the header.
    always_comb begin
        len   = {len_hi_q, len_lo_q};
        mtype = mt_q;
        bad   = (len == 16'd0) || (32'(len) > MAX_LEN) || (32'(mt_q) >= NUM_MEM);
    end

endmodule

// File: rtl/boot_seq.sv
// Boot sequencer: walks the command sequence on the byte interface,
// captures the header, streams data bytes to the memory port and
// reports the outcome once. Assumes one response pulse per command.
module boot_seq
    import boot_pkg::*;
#(
    parameter int unsigned AW      = 10,
    parameter int unsigned NUM_MEM = 4,
    parameter logic [15:0] OFFSET  = 16'h0000,
    localparam int unsigned MSEL_W = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic              cs_pin,
    output logic              cmd_valid,
    output bus_op_e           cmd_op,
    output logic [7:0]        cmd_wdata,
    input  logic              rsp_done,
    input  logic              rsp_nack,
    input  logic [7:0]        rsp_rdata,
    input  logic              wd_expire,
    output logic              hdr_we,
    output logic [1:0]        hdr_idx,
    input  logic              hdr_bad,
    input  logic [15:0]       hdr_len,
    input  logic [7:0]        hdr_mtype,
    output logic              mem_we,
    output logic [MSEL_W-1:0] mem_sel,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              arm_we,
    output logic [MSEL_W-1:0] arm_sel,
    output logic              fin,
    output fault_t            fin_fault,
    output logic              busy
);
    seq_st_e           st_q;
    logic              cs_q;
    logic [15:0]       cnt_q;
    fault_t            flt_q;
    logic              last_byte;

    // Final data byte of the announced length.
    always_comb last_byte = (cnt_q == hdr_len - 16'd1);

    // Command presented to the master engine in each state.
    always_comb begin
        cmd_valid = 1'b1;
        cmd_op    = OP_WRITE;
        cmd_wdata = 8'h00;
        case (st_q)
            ST_START:  cmd_op    = OP_START;
            ST_DEVW:   cmd_wdata = dev_byte(cs_q, 1'b0);
            ST_AHI:    cmd_wdata = OFFSET[15:8];
            ST_ALO:    cmd_wdata = OFFSET[7:0];
            ST_RSTART: cmd_op    = OP_RSTART;
            ST_DEVR:   cmd_wdata = dev_byte(cs_q, 1'b1);
            ST_HDR:    cmd_op    = OP_RD_ACK;
            ST_DATA:   cmd_op    = last_byte ? OP_RD_NACK : OP_RD_ACK;
            ST_STOP:   cmd_op    = OP_STOP;
            default:   cmd_valid = 1'b0;
        endcase
    end

    // Side strobes: header capture, error arming, completion, busy.
    always_comb begin
        hdr_we    = (st_q == ST_HDR) && rsp_done;
        hdr_idx   = cnt_q[1:0];
        arm_we    = (st_q == ST_HCHK) && !hdr_bad;
        arm_sel   = hdr_mtype[MSEL_W-1:0];
        fin       = ((st_q == ST_STOP) && rsp_done) || wd_expire;
        fin_fault = flt_q;
        if (wd_expire)
            fin_fault.timeout = 1'b1;
        busy      = (st_q != ST_IDLE) && (st_q != ST_DONE);
    end

    // Sequence state, fault capture and memory write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cs_q      <= 1'b0;
            cnt_q     <= '0;
            flt_q     <= '0;
            mem_we    <= 1'b0;
            mem_sel   <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (wd_expire) begin
                st_q <= ST_DONE;
            end else begin
                case (st_q)
                    ST_IDLE: if (load_req) begin
                        st_q <= ST_START;
                        cs_q <= cs_pin;
                    end
                    ST_START:  if (rsp_done) st_q <= ST_DEVW;
                    ST_DEVW: if (rsp_done) begin
                        if (rsp_nack) begin
                            flt_q.no_dev <= 1'b1;
                            st_q         <= ST_STOP;
                        end else
                            st_q <= ST_AHI;
                    end
                    ST_AHI, ST_ALO, ST_DEVR: if (rsp_done) begin
                        if (rsp_nack) begin
                            flt_q.nack <= 1'b1;
                            st_q       <= ST_STOP;
                        end else if (st_q == ST_AHI)
                            st_q <= ST_ALO;
                        else if (st_q == ST_ALO)
                            st_q <= ST_RSTART;
                        else begin
                            st_q  <= ST_HDR;
                            cnt_q <= '0;
                        end
                    end
                    ST_RSTART: if (rsp_done) st_q <= ST_DEVR;
                    ST_HDR: if (rsp_done) begin
                        if (cnt_q == 16'd2) begin
                            cnt_q <= '0;
                            st_q  <= ST_HCHK;
                        end else
                            cnt_q <= cnt_q + 16'd1;
                    end
                    ST_HCHK: begin
                        if (hdr_bad) begin
                            flt_q.bad_hdr <= 1'b1;
                            st_q          <= ST_STOP;
                        end else
                            st_q <= ST_DATA;
                    end
                    ST_DATA: if (rsp_done) begin
                        mem_we    <= 1'b1;
                        mem_sel   <= hdr_mtype[MSEL_W-1:0];
                        mem_addr  <= cnt_q[AW-1:0];
                        mem_wdata <= rsp_rdata;
                        cnt_q     <= cnt_q + 16'd1;
                        if (last_byte)
                            st_q <= ST_STOP;
                    end
                    ST_STOP: if (rsp_done) st_q <= ST_DONE;
                    default: st_q <= st_q;
                endcase
            end
        end
    end

endmodule

// File: rtl/boot_status.sv
// Status register: records the outcome once per reset and keeps one
// load-error bit per target memory. Assumes NUM_MEM <= 8.
module boot_status
    import boot_pkg::*;
#(
    parameter int unsigned NUM_MEM = 4,
    localparam int unsigned MSEL_W = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_we,
    input  logic [MSEL_W-1:0] arm_sel,
    input  logic              fin,
    input  fault_t            fin_fault,
    output logic [15:0]       stat_word,
    output logic              use_default
);
    logic               done_q, ok_q;
    fault_t             flt_q;
    logic [NUM_MEM-1:0] merr_q;

    // Capture the outcome and maintain the per-memory error bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ok_q   <= 1'b0;
            flt_q  <= '0;
            merr_q <= '0;
        end else begin
            if (arm_we)
                merr_q[arm_sel] <= 1'b1;
            if (fin) begin
                done_q <= 1'b1;
                flt_q  <= fin_fault;
                ok_q   <= (fin_fault == '0);
                if (fin_fault == '0)
                    merr_q <= '0;
            end
        end
    end

    // Pack the status word and the fallback indication.
    always_comb begin
        stat_word              = '0;
        stat_word[0]           = done_q;
        stat_word[1]           = ok_q;
        stat_word[2]           = flt_q.no_dev;
        stat_word[3]           = flt_q.timeout | flt_q.bad_hdr | flt_q.nack;
        stat_word[4]           = flt_q.timeout;
        stat_word[5]           = flt_q.bad_hdr;
        stat_word[6]           = flt_q.nack;
        stat_word[8 +: NUM_MEM] = merr_q;
        use_default            = done_q & ~ok_q;
    end

endmodule

// File: rtl/boot_loader_top.sv
// Boot loader top: ties the sequencer, header checker, response watchdog
// and status register together. Assumes an external I2C master engine
// answering each command with one rsp_done pulse.
module boot_loader_top #(
    parameter int unsigned AW          = 10,
    parameter int unsigned NUM_MEM     = 4,
    parameter logic [15:0] OFFSET      = 16'h0000,
    parameter int unsigned TIMEOUT_CYC = 5_000_000,
    localparam int unsigned MSEL_W     = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic              cs_pin,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [7:0]        cmd_wdata,
    input  logic              rsp_done,
    input  logic              rsp_nack,
    input  logic [7:0]        rsp_rdata,
    output logic              mem_we,
    output logic [MSEL_W-1:0] mem_sel,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              gpio_pull_low,
    output logic              use_default,
    output logic [15:0]       stat_word
);
    import boot_pkg::*;

    bus_op_e           op_w;
    logic              wd_expire;
    logic              hdr_we, hdr_bad;
    logic [1:0]        hdr_idx;
    logic [15:0]       hdr_len;
    logic [7:0]        hdr_mtype;
    logic              arm_we, fin;
    logic [MSEL_W-1:0] arm_sel;
    fault_t            fin_fault;

    // Present the command code as a plain vector.
    always_comb cmd_op = op_w;

    boot_seq #(.AW(AW), .NUM_MEM(NUM_MEM), .OFFSET(OFFSET)) seq_i (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .cs_pin(cs_pin),
        .cmd_valid(cmd_valid), .cmd_op(op_w), .cmd_wdata(cmd_wdata),
        .rsp_done(rsp_done), .rsp_nack(rsp_nack), .rsp_rdata(rsp_rdata),
        .wd_expire(wd_expire),
        .hdr_we(hdr_we), .hdr_idx(hdr_idx), .hdr_bad(hdr_bad),
        .hdr_len(hdr_len), .hdr_mtype(hdr_mtype),
        .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .arm_we(arm_we), .arm_sel(arm_sel), .fin(fin), .fin_fault(fin_fault),
        .busy(gpio_pull_low)
    );

    boot_hdr #(.AW(AW), .NUM_MEM(NUM_MEM)) hdr_i (
        .clk(clk), .rst_n(rst_n), .we(hdr_we), .idx(hdr_idx), .din(rsp_rdata),
        .len(hdr_len), .mtype(hdr_mtype), .bad(hdr_bad)
    );

    boot_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) wdog_i (
        .clk(clk), .rst_n(rst_n), .waiting(cmd_valid), .answered(rsp_done),
        .expire(wd_expire)
    );

    boot_status #(.NUM_MEM(NUM_MEM)) stat_i (
        .clk(clk), .rst_n(rst_n), .arm_we(arm_we), .arm_sel(arm_sel),
        .fin(fin), .fin_fault(fin_fault),
        .stat_word(stat_word), .use_default(use_default)
    );

endmodule

// File: rtl/boot_loader_chk.sv
// Property checker for the boot loader, attached to every instance of
// the top module. Observes ports only.
module boot_loader_chk #(
    parameter int unsigned TIMEOUT_CYC = 5_000_000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        rsp_done,
    input logic        mem_we,
    input logic        gpio_pull_low,
    input logic        use_default,
    input logic [15:0] stat_word
);
    int unsigned wait_cnt;

    // Length of the current unanswered command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_cnt <= 0;
        else if (cmd_valid && !rsp_done)
            wait_cnt <= wait_cnt + 1;
        else
            wait_cnt <= 0;
    end

    // R1
    no_stray_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gpio_pull_low |-> !cmd_valid);

    // R12
    busy_vs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_pull_low |-> !stat_word[0]);

    // R13
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[0] |=> $stable(stat_word));

    // R13
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[0] |-> (!cmd_valid && !mem_we));

    // R6
    clean_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[1] |-> (stat_word[0] && stat_word[7:2] == 6'd0));

    // R7
    nodev_not_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[2] |-> !stat_word[3]);

    // R14
    default_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_default) |-> $rose(stat_word[0]));

    // R10
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= TIMEOUT_CYC);

endmodule

bind boot_loader_top boot_loader_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .rsp_done(rsp_done),
    .mem_we(mem_we), .gpio_pull_low(gpio_pull_low), .use_default(use_default),
    .stat_word(stat_word)
);

// File: tb/boot_loader_tb.sv
// Bench: EEPROM responder on the byte interface, a scenario table and
// directed checks for reset, strap sampling and load refusal.
module boot_loader_top_tb_top;
    localparam int          AW   = 6;
    localparam int          TOUT = 40;
    localparam int          LAT  = 2;
    localparam logic [15:0] OFS  = 16'h0123;
    localparam logic [2:0]  B_START = 3'd0, B_RSTART = 3'd1, B_WRITE = 3'd2,
                            B_RDA = 3'd3, B_RDN = 3'd4, B_STOP = 3'd5;

    typedef struct packed {
        logic        cs;
        logic [15:0] len;
        logic [7:0]  mt;
        logic [7:0]  nack_at;
        logic [7:0]  hang_at;
        logic [15:0] exp_stat;
        logic [15:0] exp_wr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd5,  8'd1, 8'd0, 8'd0,  16'h0003, 16'd5},
        '{1'b1, 16'd1,  8'd3, 8'd0, 8'd0,  16'h0003, 16'd1},
        '{1'b0, 16'd64, 8'd0, 8'd0, 8'd0,  16'h0003, 16'd64},
        '{1'b1, 16'd4,  8'd2, 8'd2, 8'd0,  16'h0005, 16'd0},
        '{1'b0, 16'd4,  8'd2, 8'd3, 8'd0,  16'h0049, 16'd0},
        '{1'b1, 16'd4,  8'd2, 8'd4, 8'd0,  16'h0049, 16'd0},
        '{1'b0, 16'd4,  8'd2, 8'd6, 8'd0,  16'h0049, 16'd0},
        '{1'b0, 16'd65, 8'd2, 8'd0, 8'd0,  16'h0029, 16'd0},
        '{1'b1, 16'd0,  8'd1, 8'd0, 8'd0,  16'h0029, 16'd0},
        '{1'b0, 16'd3,  8'd4, 8'd0, 8'd0,  16'h0029, 16'd0},
        '{1'b0, 16'd4,  8'd2, 8'd0, 8'd12, 16'h0419, 16'd2},
        '{1'b1, 16'd4,  8'd2, 8'd0, 8'd8,  16'h0019, 16'd0},
        '{1'b0, 16'd6,  8'd3, 8'd0, 8'd1,  16'h0019, 16'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_req = 1'b0;
    logic        cs_pin = 1'b0;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_wdata;
    logic        rsp_done = 1'b0;
    logic        rsp_nack = 1'b0;
    logic [7:0]  rsp_rdata = 8'h00;
    logic        mem_we;
    logic [1:0]  mem_sel;
    logic [AW-1:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        gpio_pull_low, use_default;
    logic [15:0] stat_word;

    int checks = 0, fails = 0;
    int ncmd = 0, rd_idx = 0, wcnt = 0, werr = 0;
    int cur_nack = 0, cur_hang = 0;
    logic [15:0] cur_len = '0;
    logic [7:0]  cur_mt = '0;
    logic [2:0]  op_log [128];
    logic [7:0]  wd_log [128];

    always #10 clk = ~clk;

    boot_loader_top #(.AW(AW), .NUM_MEM(4), .OFFSET(OFS), .TIMEOUT_CYC(TOUT)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .cs_pin(cs_pin),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .rsp_done(rsp_done), .rsp_nack(rsp_nack), .rsp_rdata(rsp_rdata),
        .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .gpio_pull_low(gpio_pull_low), .use_default(use_default), .stat_word(stat_word)
    );

    function automatic logic [7:0] pat(int k, logic [7:0] mt);
        return 8'(k * 7 + 8'h35 + int'(mt));
    endfunction

    function automatic logic [7:0] rom(int k);
        if (k == 0) return cur_len[15:8];
        if (k == 1) return cur_len[7:0];
        if (k == 2) return cur_mt;
        return pat(k - 3, cur_mt);
    endfunction

    function automatic string out_tag(logic [15:0] s);
        if (s[4]) return "R10";
        if (s[5]) return "R9";
        if (s[6]) return "R8";
        if (s[2]) return "R7";
        return "R6";
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // EEPROM responder on the byte command interface.
    initial forever begin
        @(negedge clk);
        if (cmd_valid === 1'b1) begin
            op_log[ncmd & 127] = cmd_op;
            wd_log[ncmd & 127] = cmd_wdata;
            ncmd++;
            if (ncmd == cur_hang) begin
                while (cmd_valid === 1'b1) @(negedge clk);
            end else begin
                repeat (LAT) @(negedge clk);
                rsp_nack  = (ncmd == cur_nack);
                rsp_rdata = (cmd_op == B_RDA || cmd_op == B_RDN) ? rom(rd_idx) : 8'h00;
                if (cmd_op == B_RDA || cmd_op == B_RDN) rd_idx++;
                rsp_done  = 1'b1;
                @(negedge clk);
                rsp_done  = 1'b0;
                rsp_nack  = 1'b0;
            end
        end
    end

    // Memory-port monitor against the expected image.
    initial forever begin
        @(negedge clk);
        if (mem_we === 1'b1) begin
            if (mem_addr != AW'(wcnt) || mem_wdata != pat(wcnt, cur_mt) || mem_sel != cur_mt[1:0])
                werr++;
            wcnt++;
        end
    end

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    task automatic do_reset(input vec_t v);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        cur_len = v.len; cur_mt = v.mt;
        cur_nack = int'(v.nack_at); cur_hang = int'(v.hang_at);
        ncmd = 0; rd_idx = 0; wcnt = 0; werr = 0;
        cs_pin = v.cs;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v);
        string t;
        int n, bad_rd, early_stop, n_before;
        logic [15:0] st_before;
        do_reset(v);
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        cs_pin = ~v.cs;
        @(negedge clk);
        chk(gpio_pull_low == 1'b1, "R12", "busy during load", int'(gpio_pull_low), 1);
        for (int i = 0; i < 3000 && stat_word[0] !== 1'b1; i++) @(negedge clk);
        t = out_tag(v.exp_stat);
        chk(stat_word == v.exp_stat, t, "status word", int'(stat_word), int'(v.exp_stat));
        if (v.exp_stat[10]) chk(stat_word[10] == 1'b1, "R11", "error bit kept", int'(stat_word[10]), 1);
        chk(wcnt == int'(v.exp_wr), "R4", "memory write count", wcnt, int'(v.exp_wr));
        chk(werr == 0, "R4", "memory write content", werr, 0);
        chk(use_default == !stat_word[1], "R14", "use_default", int'(use_default), int'(!stat_word[1]));
        chk(gpio_pull_low == 1'b0, "R12", "busy released", int'(gpio_pull_low), 0);
        n = ncmd;
        chk(op_log[0] == B_START, "R3", "first op", int'(op_log[0]), int'(B_START));
        if (n >= 2) chk(wd_log[1] == {6'b101000, v.cs, 1'b0}, "R2", "write device byte",
                        int'(wd_log[1]), int'({6'b101000, v.cs, 1'b0}));
        if (n >= 4 && op_log[2] == B_WRITE && op_log[3] == B_WRITE)
            chk({wd_log[2], wd_log[3]} == OFS, "R3", "offset bytes", int'({wd_log[2], wd_log[3]}), int'(OFS));
        if (n >= 6 && op_log[4] == B_RSTART)
            chk(wd_log[5] == {6'b101000, v.cs, 1'b1}, "R2", "read device byte",
                int'(wd_log[5]), int'({6'b101000, v.cs, 1'b1}));
        if (v.hang_at == 0)
            chk(op_log[(n - 1) & 127] == B_STOP, t, "final STOP", int'(op_log[(n - 1) & 127]), int'(B_STOP));
        else
            chk(op_log[(n - 1) & 127] != B_STOP && n == int'(v.hang_at), "R10", "no STOP after hang",
                n, int'(v.hang_at));
        if (v.nack_at != 0)
            chk(n == int'(v.nack_at) + 1, t, "STOP right after NACK", n, int'(v.nack_at) + 1);
        if (v.exp_stat[1]) begin
            bad_rd = 0; early_stop = 0;
            for (int i = 6; i < 8 + int'(v.len); i++) if (op_log[i] != B_RDA) bad_rd++;
            if (op_log[8 + int'(v.len)] != B_RDN) bad_rd++;
            for (int i = 0; i < n - 1; i++) if (op_log[i] == B_STOP) early_stop++;
            chk(bad_rd == 0, "R5", "read ack pattern", bad_rd, 0);
            chk(early_stop == 0 && n == 10 + int'(v.len), "R3", "command count", n, 10 + int'(v.len));
        end
        n_before = ncmd; st_before = stat_word;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        repeat (20) @(negedge clk);
        chk(ncmd == n_before && stat_word == st_before, "R13", "second request refused",
            ncmd, n_before);
    endtask

    initial begin
        vec_t z;
        z = VECS[0];
        // R1: reset state, request during reset ignored.
        repeat (2) @(negedge clk);
        load_req = 1'b1;
        @(negedge clk);
        chk(cmd_valid == 1'b0 && gpio_pull_low == 1'b0, "R1", "idle in reset",
            int'({cmd_valid, gpio_pull_low}), 0);
        chk(stat_word == 16'h0 && use_default == 1'b0, "R1", "status in reset", int'(stat_word), 0);
        load_req = 1'b0;
        do_reset(z);
        repeat (10) @(negedge clk);
        chk(ncmd == 0 && cmd_valid == 1'b0, "R1", "no command without request", ncmd, 0);
        chk(stat_word == 16'h0, "R1", "status after reset", int'(stat_word), 0);
        for (int k = 0; k < NV; k++) run_vec(VECS[k]);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule